// File: doc/BRIEF.md
# Framed Serial Output Port

This block turns pairs of parallel I and Q samples into one bit stream on a synchronous serial link. Each frame carries the I word and then the Q word, most significant bit first. A frame sync line marks the first bit of each frame and a frame end line marks the last. The port either generates the serial clock itself by dividing the core clock, or uses an external serial clock. In the external case it synchronises that clock into the core domain and detects its edges before using them.

Sample pairs enter through a valid/ready interface that has a one-deep holding slot. While a frame is on the wire, one more pair can wait in the slot. That pair goes out in the very next bit period, with no gap. The upstream sample source cannot stall. If it presents a pair while the slot is full, the pair is discarded and a sticky overflow flag is set. The same serial clock also samples a configuration input line. A marker on the frame sync input starts a configuration word, which is collected bit by bit.

Top module: `ser_out_port`

## Requirements
- R1: With master_sel high, sclk_out stays high for div_word+1 core cycles and then low for div_word+1 core cycles, so one period is 2*(div_word+1) core cycles. The shortest period is 2 core cycles and the longest is 32.
- R2: With master_sel low, sclk_out is held low. sclk_in passes through a two-flop synchroniser and an edge detector, and the detected rising edges advance the bit stream.
- R3: A frame is W bits of in_i followed by W bits of in_q, each word sent MSB first. Only the W least significant bits of each word are used. wlen_sel maps code 0 to W=12, code 1 to W=16, code 2 to W=20 and code 3 to W=24. The code is captured together with the pair when the pair is accepted.
- R4: sdfs is high for exactly the first bit period of a frame. sdo, sdfs and sdfe change only on a rising serial clock event. In master mode they change on the same core edge that raises sclk_out, so they stay constant through the high phase.
- R5: sdfe is high for exactly the final bit period of a frame, which is bit 2W-1.
- R6: If a pair is waiting in the slot when a frame's last bit ends, its frame starts at the next rising serial clock event, with no idle bit in between.
- R7: A pair is accepted on a core edge where in_valid and in_ready are both high. in_ready is low while the holding slot is occupied. If in_valid is high while in_ready is low, that pair is discarded and overflow goes high. overflow stays high until reset.
- R8: Between frames, sdo, sdfs and sdfe are low.
- R9: sdi and sdfs_in are sampled on falling serial clock events. An sdfs_in sample of 1 marks the MSB of a CFG_W-bit word. After the last bit of that word, cfg_word holds the word and cfg_valid pulses for one core cycle.
- R10: While reset is asserted, in_ready is 1 and sclk_out, sdo, sdfs, sdfe, overflow and cfg_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Holding slot free; the pair is taken when in_valid is also high |
| in_i | input | 24 | I sample; the low W bits are sent |
| in_q | input | 24 | Q sample; the low W bits are sent |
| wlen_sel | input | 2 | Word length code, captured along with the pair |
| master_sel | input | 1 | 1: the port generates the serial clock; 0: the port uses sclk_in |
| div_word | input | 4 | Serial clock divider used in master mode |
| sclk_in | input | 1 | External serial clock used in slave mode |
| sdi | input | 1 | Serial configuration data |
| sdfs_in | input | 1 | Configuration word start marker |
| sclk_out | output | 1 | Generated serial clock; low in slave mode |
| sdo | output | 1 | Serial data out |
| sdfs | output | 1 | Frame sync, high during the first bit |
| sdfe | output | 1 | Frame end, high during the last bit |
| overflow | output | 1 | Sticky flag for a discarded pair |
| cfg_word | output | 16 | Last configuration word collected |
| cfg_valid | output | 1 | One-cycle pulse when cfg_word is updated |

## Verification
Single frames are sent with each of the four word lengths, using random samples whose unused upper bits are also random. This separates the length decode, the bit order and the I/Q order. Pairs sent back to back with the fastest divider show whether the waiting pair follows the last bit with no gap. A third pair sent while the slot is full shows that the discard and the sticky flag take effect without corrupting the two frames already in flight. The same traffic is repeated with divider values from 0 to 15 and with an external slave clock, to tell the generated clock timing apart from the synchronised edge path. Configuration words are sent in both clock modes.

// File: rtl/sop_pkg.sv
package sop_pkg;
  localparam int MAXW = 24;
  localparam int FRW  = 2 * MAXW;

  typedef struct packed {
    logic [1:0]      wl;
    logic [MAXW-1:0] i;
    logic [MAXW-1:0] q;
  } pair_t;

  function automatic int word_bits(input logic [1:0] code);
    return 12 + 4 * int'(code);
  endfunction
endpackage

// File: rtl/sop_clkgen.sv
module sop_clkgen #(
  parameter int DIVW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            master,
  input  logic [DIVW-1:0] div,
  input  logic            sclk_ext,
  input  logic            sdi,
  input  logic            sdfs_ext,
  output logic            sclk_o,
  output logic            rise_evt,
  output logic            fall_evt,
  output logic            sdi_s,
  output logic            sdfs_s
);
  logic [DIVW-1:0] cnt;
  logic            sclk_q;
  logic            m_tick;
  logic [2:0]      sync_c;
  logic [1:0]      sync_d;
  logic [1:0]      sync_f;
  logic            s_rise;
  logic            s_fall;

  // master divider: toggle after div+1 core cycles
  assign m_tick = master && (cnt >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      sclk_q <= 1'b0;
    end else if (!master) begin
      cnt    <= '0;
      sclk_q <= 1'b0;
    end else if (m_tick) begin
      cnt    <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt    <= cnt + 1'b1;
    end
  end

  // slave path: external clock and its companion lines share one delay
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_c <= '0;
      sync_d <= '0;
      sync_f <= '0;
    end else begin
      sync_c <= {sync_c[1:0], sclk_ext};
      sync_d <= {sync_d[0], sdi};
      sync_f <= {sync_f[0], sdfs_ext};
    end
  end

  assign s_rise   = sync_c[1] & ~sync_c[2];
  assign s_fall   = ~sync_c[1] & sync_c[2];
  assign rise_evt = master ? (m_tick & ~sclk_q) : s_rise;
  assign fall_evt = master ? (m_tick & sclk_q) : s_fall;
  assign sdi_s    = master ? sdi : sync_d[1];
  assign sdfs_s   = master ? sdfs_ext : sync_f[1];
  assign sclk_o   = sclk_q;

  a_r1_rise_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> !rise_evt);
  a_r1_evt_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_evt && fall_evt));
  a_r1_rise_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
    (master && rise_evt) |=> (!master || sclk_o));
  a_r2_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !master |=> (master || !sclk_o));
endmodule

// File: rtl/sop_slot.sv
module sop_slot
  import sop_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  input  pair_t in_pair,
  input  logic  take,
  output logic  in_ready,
  output logic  slot_full,
  output pair_t slot_pair,
  output logic  overflow
);
  logic accept;

  assign in_ready = ~slot_full;
  assign accept   = in_valid & ~slot_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_full <= 1'b0;
      slot_pair <= '0;
      overflow  <= 1'b0;
    end else begin
      if (accept) begin
        slot_full <= 1'b1;
        slot_pair <= in_pair;
      end else if (take) begin
        slot_full <= 1'b0;
      end
      if (in_valid && slot_full) overflow <= 1'b1;
    end
  end

  a_r7_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> overflow);
  a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  a_r7_take_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> slot_full);
endmodule

// File: rtl/sop_shifter.sv
module sop_shifter
  import sop_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rise_evt,
  input  logic  slot_full,
  input  pair_t slot_pair,
  output logic  take,
  output logic  sdo,
  output logic  sdfs,
  output logic  sdfe,
  output logic  busy
);
  localparam int IDXW = $clog2(FRW);

  logic [FRW-1:0]  shreg;
  logic [FRW-1:0]  frame_img;
  logic [IDXW-1:0] idx;
  logic [IDXW-1:0] last_idx;
  logic [IDXW-1:0] load_last;
  logic            active;
  logic            at_last;

  // left-justify I then Q, each cut to its low w bits
  always_comb begin
    int w;
    w = word_bits(slot_pair.wl);
    frame_img = '0;
    for (int k = 0; k < MAXW; k++) begin
      if (k < w) begin
        frame_img[FRW-1-k]   = slot_pair.i[w-1-k];
        frame_img[FRW-1-w-k] = slot_pair.q[w-1-k];
      end
    end
  end

  assign load_last = IDXW'(2 * word_bits(slot_pair.wl) - 1);
  assign at_last   = (idx == last_idx);
  assign take      = rise_evt && slot_full && (!active || at_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      idx      <= '0;
      last_idx <= '0;
      active   <= 1'b0;
    end else if (take) begin
      shreg    <= frame_img;
      idx      <= '0;
      last_idx <= load_last;
      active   <= 1'b1;
    end else if (rise_evt && active) begin
      if (at_last) begin
        active <= 1'b0;
      end else begin
        shreg <= {shreg[FRW-2:0], 1'b0};
        idx   <= idx + 1'b1;
      end
    end
  end

  assign sdo  = active & shreg[FRW-1];
  assign sdfs = active & (idx == '0);
  assign sdfe = active & at_last;
  assign busy = active;

  a_r4_fs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sdfs && !rise_evt) |=> sdfs);
  a_r4_fs_single: assert property (@(posedge clk) disable iff (!rst_n)
    (sdfs && rise_evt) |=> !sdfs);
  a_r4_change_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_evt |=> ($stable(sdo) && $stable(sdfs) && $stable(sdfe)));
  a_r5_fe_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (sdfe && rise_evt) |=> (sdfs || !busy));
  a_r6_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (sdfe && rise_evt && slot_full) |=> sdfs);
endmodule

// File: rtl/sop_cfgcap.sv
module sop_cfgcap #(
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_evt,
  input  logic             sdi_s,
  input  logic             sdfs_s,
  output logic [CFG_W-1:0] cfg_word,
  output logic             cfg_valid
);
  localparam int CW = $clog2(CFG_W + 1);

  logic [CFG_W-1:0] sh;
  logic [CW-1:0]    got;
  logic             collecting;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh         <= '0;
      got        <= '0;
      collecting <= 1'b0;
      cfg_word   <= '0;
      cfg_valid  <= 1'b0;
    end else begin
      cfg_valid <= 1'b0;
      if (fall_evt) begin
        if (sdfs_s) begin
          sh         <= {sh[CFG_W-2:0], sdi_s};
          got        <= CW'(1);
          collecting <= 1'b1;
        end else if (collecting) begin
          sh  <= {sh[CFG_W-2:0], sdi_s};
          got <= got + 1'b1;
          if (got == CW'(CFG_W - 1)) begin
            cfg_word   <= {sh[CFG_W-2:0], sdi_s};
            cfg_valid  <= 1'b1;
            collecting <= 1'b0;
          end
        end
      end
    end
  end

  a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> !cfg_valid);
  a_r9_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_valid) |-> $past(fall_evt));
endmodule

// File: rtl/ser_out_port.sv
module ser_out_port
  import sop_pkg::*;
#(
  parameter int CFG_W = 16,
  parameter int DIVW  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [MAXW-1:0]  in_i,
  input  logic [MAXW-1:0]  in_q,
  input  logic [1:0]       wlen_sel,
  input  logic             master_sel,
  input  logic [DIVW-1:0]  div_word,
  input  logic             sclk_in,
  input  logic             sdi,
  input  logic             sdfs_in,
  output logic             sclk_out,
  output logic             sdo,
  output logic             sdfs,
  output logic             sdfe,
  output logic             overflow,
  output logic [CFG_W-1:0] cfg_word,
  output logic             cfg_valid
);
  logic  rise_evt;
  logic  fall_evt;
  logic  sdi_s;
  logic  sdfs_s;
  logic  take;
  logic  slot_full;
  logic  busy;
  pair_t in_pair;
  pair_t slot_pair;

  assign in_pair = '{wl: wlen_sel, i: in_i, q: in_q};

  sop_clkgen #(.DIVW(DIVW)) u_clk (
    .clk(clk), .rst_n(rst_n), .master(master_sel), .div(div_word),
    .sclk_ext(sclk_in), .sdi(sdi), .sdfs_ext(sdfs_in),
    .sclk_o(sclk_out), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .sdi_s(sdi_s), .sdfs_s(sdfs_s)
  );

  sop_slot u_slot (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pair(in_pair),
    .take(take), .in_ready(in_ready), .slot_full(slot_full),
    .slot_pair(slot_pair), .overflow(overflow)
  );

  sop_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .slot_full(slot_full),
    .slot_pair(slot_pair), .take(take), .sdo(sdo), .sdfs(sdfs),
    .sdfe(sdfe), .busy(busy)
  );

  sop_cfgcap #(.CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .fall_evt(fall_evt), .sdi_s(sdi_s),
    .sdfs_s(sdfs_s), .cfg_word(cfg_word), .cfg_valid(cfg_valid)
  );

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sdo && !sdfs && !sdfe));
endmodule

// File: tb/tb_ser_out_port.sv
`timescale 1ns/1ps
module tb_ser_out_port;
  import sop_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_i = '0;
  logic [23:0] in_q = '0;
  logic [1:0]  wlen_sel = '0;
  logic        master_sel = 1'b1;
  logic [3:0]  div_word = 4'd1;
  logic        sclk_in = 1'b0;
  logic        sdi = 1'b0;
  logic        sdfs_in = 1'b0;
  logic        sclk_out, sdo, sdfs, sdfe, overflow, cfg_valid;
  logic [15:0] cfg_word;

  always #2 clk = ~clk;

  ser_out_port #(.CFG_W(16), .DIVW(4)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_i(in_i), .in_q(in_q), .wlen_sel(wlen_sel), .master_sel(master_sel),
    .div_word(div_word), .sclk_in(sclk_in), .sdi(sdi), .sdfs_in(sdfs_in),
    .sclk_out(sclk_out), .sdo(sdo), .sdfs(sdfs), .sdfe(sdfe),
    .overflow(overflow), .cfg_word(cfg_word), .cfg_valid(cfg_valid)
  );

  typedef struct {
    logic [23:0] i;
    logic [23:0] q;
    int          w;
    bit          b2b;
  } exp_t;

  exp_t       exp_q[$];
  logic [1:0] cfg_bits[$];
  int  checks = 0;
  int  fails = 0;
  bit  in_fr = 1'b0;
  bit  slave_run = 1'b0;
  bit  finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // external serial clock, 16 core cycles per period
  initial begin
    int sc_cnt = 0;
    forever begin
      @(posedge clk); #1;
      if (slave_run) begin
        if (sc_cnt == 7) begin sc_cnt = 0; sclk_in = ~sclk_in; end
        else sc_cnt++;
      end else begin
        sclk_in = 1'b0;
        sc_cnt = 0;
      end
    end
  end

  // monitor: scoreboard on serial output, also drives config bits on rises
  initial begin
    bit prev = 1'b0, obs;
    int cyc = 0, last_rise = -1, k = 0, w = 0, fall_n = 0, end_fall = -100;
    exp_t cur;
    logic [3:0] rise_div = '0;
    bit rise_mode = 1'b0;
    logic r_sdo = 1'b0, r_fs = 1'b0, r_fe = 1'b0;
    logic [1:0] cb;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst_n) begin prev = 1'b0; last_rise = -1; continue; end
      obs = master_sel ? sclk_out : sclk_in;
      if (obs && !prev) begin
        if (master_sel && rise_mode && last_rise >= 0 && rise_div == div_word)
          chk((cyc - last_rise) == 2 * (int'(div_word) + 1), "R1", "sclk period",
              cyc - last_rise, 2 * (int'(div_word) + 1));
        last_rise = cyc; rise_div = div_word; rise_mode = master_sel;
        r_sdo = sdo; r_fs = sdfs; r_fe = sdfe;
        if (cfg_bits.size() > 0) begin
          cb = cfg_bits.pop_front();
          sdfs_in = cb[1]; sdi = cb[0];
        end else begin
          sdfs_in = 1'b0; sdi = 1'b0;
        end
      end
      if (!obs && prev) begin
        fall_n++;
        if (master_sel && rise_mode)
          chk({r_sdo, r_fs, r_fe} == {sdo, sdfs, sdfe}, "R4", "outputs moved in high phase",
              {sdo, sdfs, sdfe}, {r_sdo, r_fs, r_fe});
        if (!master_sel && !rise_mode)
          chk(sclk_out == 1'b0, "R2", "sclk_out in slave", sclk_out, 0);
        if (!in_fr && sdfs) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R3", "unexpected frame", 1, 0);
          end else begin
            cur = exp_q.pop_front();
            w = cur.w; k = 0; in_fr = 1'b1;
            if (cur.b2b) chk(fall_n == end_fall + 1, "R6", "gap before frame", fall_n, end_fall + 1);
          end
        end
        if (in_fr) begin
          logic eb;
          eb = (k < w) ? cur.i[w-1-k] : cur.q[2*w-1-k];
          chk(sdo == eb, "R3", $sformatf("bit %0d of %0d", k, 2*w), sdo, eb);
          chk(sdfs == (k == 0), "R4", $sformatf("sdfs at bit %0d", k), sdfs, k == 0);
          chk(sdfe == (k == 2*w-1), "R5", $sformatf("sdfe at bit %0d", k), sdfe, k == 2*w-1);
          k++;
          if (k == 2*w) begin in_fr = 1'b0; end_fall = fall_n; end
        end else begin
          chk(!sdo && !sdfe && !sdfs, "R8", "idle lines", {sdo, sdfs, sdfe}, 0);
        end
      end
      prev = obs;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic send(input logic [23:0] i, input logic [23:0] q,
                      input logic [1:0] wl, input bit b2b);
    exp_t e;
    tick();
    while (!in_ready) tick();
    in_i = i; in_q = q; wlen_sel = wl; in_valid = 1'b1;
    e.i = i; e.q = q; e.w = 12 + 4 * int'(wl); e.b2b = b2b;
    exp_q.push_back(e);
    tick();
    in_valid = 1'b0;
    wlen_sel = $urandom;
  endtask

  task automatic wait_idle();
    int n = 0;
    tick();
    while ((exp_q.size() != 0 || in_fr || !in_ready) && n < 20000) begin tick(); n++; end
    chk(n < 20000, "R3", "frames drained", exp_q.size(), 0);
    repeat (80) tick();
  endtask

  task automatic send_cfg(input logic [15:0] word);
    int n = 0;
    for (int b = 15; b >= 0; b--) cfg_bits.push_back({(b == 15), word[b]});
    while (!cfg_valid && n < 4000) begin @(negedge clk); n++; end
    chk(cfg_valid == 1'b1, "R9", "cfg_valid pulse", cfg_valid, 1);
    chk(cfg_word == word, "R9", "cfg_word", cfg_word, word);
    tick();
    chk(cfg_valid == 1'b0, "R9", "cfg_valid one cycle", cfg_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog run actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk(in_ready == 1'b1, "R10", "in_ready", in_ready, 1);
    chk({sclk_out, sdo, sdfs, sdfe} == 4'b0, "R10", "serial outputs", {sclk_out, sdo, sdfs, sdfe}, 0);
    chk(overflow == 1'b0 && cfg_valid == 1'b0, "R10", "flags", {overflow, cfg_valid}, 0);
    rst_n = 1'b1;
    repeat (10) tick();

    // every word length, single frames, div 1
    for (int c = 0; c < 4; c++) begin
      send($urandom, $urandom, 2'(c), 1'b0);
      wait_idle();
    end

    // fastest divider, back to back
    div_word = 4'd0;
    send($urandom, $urandom, 2'd3, 1'b0);
    send($urandom, $urandom, 2'd3, 1'b1);
    wait_idle();

    // overflow: slot full, third pair discarded
    div_word = 4'd3;
    send(24'hABC123, 24'h456DEF, 2'd0, 1'b0);
    send(24'h0F0F0F, 24'hF0F0F0, 2'd0, 1'b1);
    chk(in_ready == 1'b0, "R7", "ready low with slot full", in_ready, 0);
    chk(overflow == 1'b0, "R7", "no overflow yet", overflow, 0);
    in_i = 24'hFFFFFF; in_q = 24'hFFFFFF; in_valid = 1'b1;
    tick();
    in_valid = 1'b0;
    chk(overflow == 1'b1, "R7", "overflow after drop", overflow, 1);
    wait_idle();
    chk(overflow == 1'b1, "R7", "overflow sticky", overflow, 1);
    chk(in_ready == 1'b1, "R7", "ready back", in_ready, 1);

    // slowest divider
    div_word = 4'd15;
    send($urandom, $urandom, 2'd1, 1'b0);
    wait_idle();

    // configuration input, master clock
    div_word = 4'd2;
    repeat (20) tick();
    send_cfg(16'hA5C3);

    // slave clock
    master_sel = 1'b0;
    slave_run = 1'b1;
    repeat (40) tick();
    send($urandom, $urandom, 2'd2, 1'b0);
    send($urandom, $urandom, 2'd0, 1'b1);
    wait_idle();
    send_cfg(16'h3C96);

    repeat (100) tick();
    chk(exp_q.size() == 0, "R3", "scoreboard empty", exp_q.size(), 0);
    summary();
  end
endmodule